// File: doc/BRIEF.md
# Energy pulse width limiter

This block turns the single-cycle pulse requests of a metering engine into low-active output pulses of bounded width. Time is measured in sample ticks, which arrive as a one-cycle strobe from the surrounding clocking logic. An 8-bit width setting gives the low time as an odd number of ticks. The all-ones value of that setting turns width control off: each request then toggles the pin, so two requests make one output period at 50% duty.

An 8-bit spacing setting controls how requests are released. At zero, a request starts a pulse on the next clock when the shaper is idle. At a nonzero value, requests wait in a small token queue, and successive pulse starts are kept at least that many ticks apart. When the queue is full, further requests are dropped and a sticky flag is raised. A request that arrives while a width-limited pulse is low is held until that pulse has ended. It is never folded into the running pulse.

Top module: `pls_width_limiter`

## Requirements
- R1: After reset `pulse_no` is 1 and `ovf_o` is 0.
- R2: With `max_width_i` = W below 255, each pulse holds `pulse_no` low for exactly 2*W+1 tick strobes, counted from the first clock edge after the pulse starts.
- R3: With `max_width_i` = 255, each released request inverts `pulse_no` one clock after it is accepted, and the level stays put between requests whatever the ticks do.
- R4: With `interval_i` = 0 and the block idle, a request sampled on a clock edge drives `pulse_no` low from that same edge.
- R5: A request that arrives during a width-limited pulse starts a new pulse only after that pulse ends, with `pulse_no` high for at least one clock in between. The pending request is not lost.
- R6: With `interval_i` = N greater than 0, successive pulse starts are exactly N ticks apart when requests are waiting, where the ticks are counted on the edges after the earlier start.
- R7: The queue holds 4 waiting requests. A request that arrives while 4 are waiting and none is released is dropped, and it sets `ovf_o`.
- R8: `ovf_o` stays 1 until reset, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick strobe, one cycle wide |
| req_i | input | 1 | Pulse request strobe from the metering engine |
| max_width_i | input | 8 | Width setting W: low time is 2*W+1 ticks; 255 selects toggle mode |
| interval_i | input | 8 | Minimum spacing between pulse starts in ticks; 0 means release at once |
| pulse_no | output | 1 | Energy pulse, active low |
| ovf_o | output | 1 | Sticky flag set when a request is dropped because the queue is full |

## Verification
A wrong width counter shows up as a low time that is off by one or more ticks. This is visible within one pulse of at most 511 ticks. A queue count that drifts shows up in two ways: as a missing or extra pulse while a backlog drains, or as `ovf_o` rising after one request too few or too many. A spacing counter that is loaded or cleared at the wrong time shifts the second pulse start of a back-to-back burst by one tick. A lost pending request shows up as no second pulse after the first one ends.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int unsigned PLS_DEPTH = 4;
  localparam int unsigned PLS_WW    = 8;
  localparam int unsigned PLS_IW    = 8;

  typedef enum logic {
    SHAPE_WIDTH = 1'b0,
    SHAPE_DUTY  = 1'b1
  } shape_mode_e;
endpackage

// File: rtl/pls_token_q.sv
module pls_token_q #(
  parameter int unsigned DEPTH = pls_pkg::PLS_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          grant_i,
  output logic          pop_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          store, take;

  assign full  = (cnt_q == CW'(DEPTH));
  // a fresh request may pass straight through when nothing waits
  assign pop_o = grant_i & ((cnt_q != '0) | push_i);
  assign store = push_i & ~pop_o;
  assign take  = pop_o & ~push_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (store && full) ovf_o <= 1'b1;
      else if (store)    cnt_q <= cnt_q + CW'(1);
      else if (take)     cnt_q <= cnt_q - CW'(1);
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pls_spacer.sv
module pls_spacer #(
  parameter int unsigned IW = pls_pkg::PLS_IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [IW-1:0] interval_i,
  output logic          ok_o
);
  logic [IW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= '0;
    else if (load_i)                 gap_q <= interval_i;
    else if (tick_i && gap_q != '0)  gap_q <= gap_q - IW'(1);
  end

  assign ok_o = (interval_i == '0) | (gap_q == '0);
endmodule

// File: rtl/pls_shaper.sv
module pls_shaper
  import pls_pkg::*;
#(
  parameter int unsigned WW = PLS_WW,
  localparam int unsigned CW = WW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [WW-1:0] max_width_i,
  output logic          ready_o,
  output logic          active_o,
  output logic          pulse_no
);
  shape_mode_e   mode;
  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          level_q;

  assign mode = (max_width_i == '1) ? SHAPE_DUTY : SHAPE_WIDTH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      level_q  <= 1'b1;
    end else if (start_i) begin
      if (mode == SHAPE_DUTY) begin
        level_q  <= ~level_q;
        active_q <= 1'b0;
      end else begin
        level_q  <= 1'b0;
        active_q <= 1'b1;
        cnt_q    <= {max_width_i, 1'b1};
      end
    end else if (active_q) begin
      if (tick_i) begin
        if (cnt_q == CW'(1)) begin
          active_q <= 1'b0;
          level_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end else if (mode == SHAPE_WIDTH) begin
      level_q <= 1'b1;  // idle level after leaving toggle mode
    end
  end

  assign ready_o  = (mode == SHAPE_DUTY) | ~active_q;
  assign active_o = active_q;
  assign pulse_no = level_q;
endmodule

// File: rtl/pls_width_limiter.sv
module pls_width_limiter
  import pls_pkg::*;
#(
  parameter int unsigned DEPTH = PLS_DEPTH,
  parameter int unsigned WW    = PLS_WW,
  parameter int unsigned IW    = PLS_IW,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic [WW-1:0] max_width_i,
  input  logic [IW-1:0] interval_i,
  output logic          pulse_no,
  output logic          ovf_o
);
  logic          q_pop;
  logic [CW-1:0] q_count;
  logic          spc_ok;
  logic          shp_ready;
  logic          shp_active;

  pls_token_q #(.DEPTH(DEPTH)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (req_i),
    .grant_i (shp_ready & spc_ok),
    .pop_o   (q_pop),
    .count_o (q_count),
    .ovf_o   (ovf_o)
  );

  pls_spacer #(.IW(IW)) u_spc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (q_pop),
    .interval_i (interval_i),
    .ok_o       (spc_ok)
  );

  pls_shaper #(.WW(WW)) u_shp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .start_i     (q_pop),
    .max_width_i (max_width_i),
    .ready_o     (shp_ready),
    .active_o    (shp_active),
    .pulse_no    (pulse_no)
  );
endmodule

// File: rtl/pls_width_limiter_chk.sv
module pls_width_limiter_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WW    = 8,
  parameter int unsigned IW    = 8,
  parameter int unsigned CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic [WW-1:0] max_width_i,
  input logic [IW-1:0] interval_i,
  input logic          pulse_no,
  input logic          ovf_o,
  input logic          pop_i,
  input logic [CW-1:0] count_i,
  input logic          active_i,
  input logic          gap_ok_i
);
  logic duty;
  assign duty = (max_width_i == '1);

  // R7
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(ovf_o));

  // R5
  no_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !duty) |-> !active_i);

  // R6
  spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && interval_i != '0) |=> (!gap_ok_i || interval_i == '0));

  // R2
  end_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_i) |-> ($past(tick_i) || $past(pop_i)));

  // R4
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !duty) |=> !pulse_no);

  // R3
  duty_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && duty) |=> (pulse_no != $past(pulse_no)));
endmodule

bind pls_width_limiter pls_width_limiter_chk #(
  .DEPTH(DEPTH), .WW(WW), .IW(IW), .CW(CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .max_width_i (max_width_i),
  .interval_i  (interval_i),
  .pulse_no    (pulse_no),
  .ovf_o       (ovf_o),
  .pop_i       (q_pop),
  .count_i     (q_count),
  .active_i    (shp_active),
  .gap_ok_i    (spc_ok)
);

// File: tb/sim_pls_width_limiter.sv
module sim_pls_width_limiter;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WDOG       = 150000;
  // {W, expected low ticks}
  localparam logic [15:0] VEC [4] = '{
    {8'd0, 8'd1}, {8'd1, 8'd3}, {8'd3, 8'd7}, {8'd10, 8'd21}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] max_width_i = 8'hFF;
  logic [7:0] interval_i = 8'h00;
  logic       pulse_no;
  logic       ovf_o;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;

  pls_width_limiter u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i),
    .max_width_i(max_width_i), .interval_i(interval_i),
    .pulse_no(pulse_no), .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    int c = 0;
    forever begin
      @(posedge clk_i);
      #1;
      c = (c == TICK_DIV - 1) ? 0 : c + 1;
      tick_i = (c == TICK_DIV - 1);
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk_i); #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  // request high for n cycles, returns 1 time unit after the last sampling edge
  task automatic send(input int n);
    @(posedge clk_i); #1 req_i = 1'b1;
    repeat (n) @(posedge clk_i);
    #1 req_i = 1'b0;
  endtask

  // counts ticks while pulse_no is low, starting at the current negedge
  task automatic low_ticks(output int t);
    int g = 0;
    t = 0;
    while (pulse_no == 1'b0 && g < 5000) begin
      if (tick_i) t++;
      @(negedge clk_i);
      g++;
    end
  endtask

  // counts ticks from the current negedge up to the next falling edge of pulse_no
  task automatic ticks_to_fall(output int t);
    logic p;
    int g = 0;
    t = 0;
    p = pulse_no;
    forever begin
      if (tick_i) t++;
      @(negedge clk_i);
      g++;
      if ((p && !pulse_no) || g > 5000) break;
      p = pulse_no;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int t;
    int falls;
    logic p;
    do_reset();
    @(negedge clk_i);
    chk(pulse_no == 1'b1, "R1 pulse idle", int'(pulse_no), 1);
    chk(ovf_o == 1'b0, "R1 ovf clear", int'(ovf_o), 0);

    // table: width mode, pass-through
    interval_i = 8'd0;
    for (int i = 0; i < 4; i++) begin
      max_width_i = VEC[i][15:8];
      send(1);
      @(negedge clk_i);
      chk(pulse_no == 1'b0, "R4 starts at once", int'(pulse_no), 0);
      low_ticks(t);
      chk(t == int'(VEC[i][7:0]), "R2 low width", t, int'(VEC[i][7:0]));
      repeat (3) @(negedge clk_i);
    end

    // R5: request during an active pulse is held, not merged
    max_width_i = 8'd2;
    send(1);
    @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    send(1);
    @(negedge clk_i);
    chk(pulse_no == 1'b0, "R5 first pulse still low", int'(pulse_no), 0);
    low_ticks(t);
    chk(pulse_no == 1'b1, "R5 high gap between pulses", int'(pulse_no), 1);
    @(negedge clk_i);
    chk(pulse_no == 1'b0, "R5 held request released", int'(pulse_no), 0);
    low_ticks(t);
    chk(t == 5, "R5 second pulse full width", t, 5);
    repeat (3) @(negedge clk_i);

    // R3: toggle mode
    max_width_i = 8'hFF;
    send(1);
    @(negedge clk_i);
    chk(pulse_no == 1'b0, "R3 first toggle", int'(pulse_no), 0);
    repeat (40) @(negedge clk_i);
    chk(pulse_no == 1'b0, "R3 holds between requests", int'(pulse_no), 0);
    send(1);
    @(negedge clk_i);
    chk(pulse_no == 1'b1, "R3 second toggle", int'(pulse_no), 1);
    send(1);
    @(negedge clk_i);
    chk(pulse_no == 1'b0, "R3 third toggle", int'(pulse_no), 0);
    send(1);
    @(negedge clk_i);
    chk(pulse_no == 1'b1, "R3 fourth toggle", int'(pulse_no), 1);

    // R6: spacing with a backlog
    max_width_i = 8'd0;
    interval_i  = 8'd3;
    send(3);
    @(negedge clk_i);
    chk(pulse_no == 1'b0, "R6 first release", int'(pulse_no), 0);
    ticks_to_fall(t);
    chk(t == 3, "R6 spacing first gap", t, 3);
    ticks_to_fall(t);
    chk(t == 3, "R6 spacing second gap", t, 3);

    // R7/R8: overflow and drop
    do_reset();
    interval_i = 8'd50;
    send(1);
    @(negedge clk_i);
    chk(pulse_no == 1'b0, "R7 first request released", int'(pulse_no), 0);
    send(4);
    @(negedge clk_i);
    chk(ovf_o == 1'b0, "R7 four waiting no overflow", int'(ovf_o), 0);
    send(1);
    @(negedge clk_i);
    chk(ovf_o == 1'b1, "R7 fifth waiting overflows", int'(ovf_o), 1);
    falls = 0;
    p = pulse_no;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk_i);
      if (p && !pulse_no) falls++;
      p = pulse_no;
    end
    chk(falls == 4, "R7 dropped request not emitted", falls, 4);
    chk(ovf_o == 1'b1, "R8 overflow sticky", int'(ovf_o), 1);
    do_reset();
    @(negedge clk_i);
    chk(ovf_o == 1'b0, "R8 reset clears overflow", int'(ovf_o), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule